// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Core

This block is a single-port synchronous static memory built for cache-line style traffic. A cycle that asserts one of two address strobes latches a start address. Later cycles either step a 2-bit beat counter (advance) or hold it (suspend). The beat counter covers four beats. The low two address bits follow it either by modulo-4 addition (linear order) or by XOR with the start bits (interleaved order). The order is chosen by a mode input sampled when the burst begins. The strobe meant for a processor can only start reads. The strobe meant for a memory controller can start reads or writes.

The shared data bus is modelled as a separate input, an output and an output enable. Write data is taken in the same cycle as its address. Read data follows after one edge in flow-through form (`PIPE=0`) or two edges in registered form (`PIPE=1`). When the chip is deselected, the bus is released either one slot later (single-cycle deselect) or two slots later (double-cycle deselect, `DCD=1`). The double-cycle form only takes effect in registered form. Memory depth, data width and write-lane width are parameters. The default width is 36 bits in four 9-bit lanes.

Top module: `ssr_core`

## Requirements
- R1: While `rst` is high and after its release, `dq_oe` is 0 and `dq_out` is all zero until the first read data is presented.
- R2: A cycle with `chip_en`=1, `strobe_ctl`=1 and `strobe_cpu`=0 latches `addr` as the burst start and accesses that address. If any `wr_lane` bit is set, the cycle is a write: lane i (bits 9i+8..9i) of `dq_in` is stored when `wr_lane[i]`=1. Otherwise the cycle is a read.
- R3: A cycle with `chip_en`=1 and `strobe_cpu`=1 latches `addr` and always reads, whatever `strobe_ctl` and `wr_lane` are; memory is left unchanged.
- R4: A cycle with `chip_en`=1, no strobe and `adv`=1 adds 1 modulo 4 to the beat count. The upper address bits come from the start address. The low two bits are start+count modulo 4 when `order_ilv` was 0 at the begin cycle, or start XOR count when it was 1. The cycle reads or writes as in R2.
- R5: The fifth beat of a burst returns to the start address, and the same four-address sequence repeats for as long as advancing continues.
- R6: A cycle with `chip_en`=1, no strobe and `adv`=0 accesses the same address as the previous access, as a read or a write as in R2.
- R7: Data read at edge k is on `dq_out` with `dq_oe`=1 when sampled at edge k+1 (`PIPE`=0) or k+2 (`PIPE`=1). `dq_oe` is 0 in every other slot, except as R9 allows. `dq_out` keeps the last presented read data.
- R8: A read of an address in the cycle after a write to it returns the new lanes together with the unwritten old lanes.
- R9: A cycle with `chip_en`=0 performs no access and keeps the burst state; strobes, `adv` and `wr_lane` are ignored. With `DCD`=0 the bus is released in that cycle's slot. With `DCD`=1 and `PIPE`=1, if the slot before was read data, `dq_oe` stays 1 for one more slot with that data held.
- R10: A write may follow a read on the very next cycle. The read's data is still presented in its slot, and `dq_oe` is 0 in the write's slot.
- R11: With `PIPE`=0 the `DCD` setting has no effect: the bus is always released in the deselect cycle's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable; 0 makes the cycle a deselect |
| strobe_cpu | input | 1 | Processor-side address strobe, starts read bursts only |
| strobe_ctl | input | 1 | Controller-side address strobe, starts read or write bursts |
| adv | input | 1 | Advance the beat counter when no strobe is given |
| order_ilv | input | 1 | Burst order taken at begin: 0 linear, 1 interleaved |
| wr_lane | input | DATA_W/LANE_W | Per-lane write enables; any bit set makes a write |
| addr | input | ADDR_W | External start address |
| dq_in | input | DATA_W | Write data, taken in the address cycle |
| dq_out | output | DATA_W | Read data |
| dq_oe | output | 1 | High when the block drives the data bus |

## Verification
A beat counter or order flag that is off by one shows up as wrong data in the output slot of the next read beat. That is one edge later in flow-through form and two edges later in registered form. An error in the output-stage pipeline shows as `dq_oe` high or low in the wrong slot, at the very first read, write or deselect that follows. A corrupted array word or a misplaced lane stays hidden until that address is read again, so every word is first given a known value and then read back under random burst traffic. Two instances, one registered with double-cycle deselect and one flow-through with the same setting requested, are compared on every clock against a behavioural model.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    typedef enum logic [1:0] {
        CY_DESEL,
        CY_BEGIN,
        CY_CONT,
        CY_SUSP
    } cyc_e;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_RD,
        OP_WR
    } op_e;

    typedef struct packed {
        cyc_e kind;
        op_e  op;
    } slot_t;

    // low two address bits of a beat, given the start bits and beat count
    function automatic logic [1:0] beat_low(input logic [1:0] start_lo,
                                            input logic [1:0] count,
                                            input logic       ilv);
        return ilv ? (start_lo ^ count) : (start_lo + count);
    endfunction

endpackage

// File: rtl/ssr_burst_ctrl.sv
module ssr_burst_ctrl
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              strobe_cpu,
    input  logic              strobe_ctl,
    input  logic              adv,
    input  logic              order_ilv,
    input  logic [LANES-1:0]  wr_lane,
    input  logic [ADDR_W-1:0] addr,
    output slot_t             acc,
    output logic [ADDR_W-1:0] acc_addr
);

    cyc_e              kind;
    logic [ADDR_W-1:0] start_q, start_d;
    logic [1:0]        beat_q, beat_d;
    logic              ilv_q, ilv_d;
    logic              armed_q;

    always_comb begin
        kind = CY_DESEL;
        if (chip_en) begin
            if (strobe_cpu || strobe_ctl) kind = CY_BEGIN;
            else if (adv)                 kind = CY_CONT;
            else                          kind = CY_SUSP;
        end

        start_d = start_q;
        beat_d  = beat_q;
        ilv_d   = ilv_q;
        case (kind)
            CY_BEGIN: begin
                start_d = addr;
                beat_d  = 2'd0;
                ilv_d   = order_ilv;
            end
            CY_CONT:  beat_d = beat_q + 2'd1;
            default:  ;
        endcase

        acc_addr = {start_d[ADDR_W-1:2], beat_low(start_d[1:0], beat_d, ilv_d)};

        acc.kind = kind;
        if (kind == CY_DESEL)                acc.op = OP_IDLE;
        else if ((|wr_lane) && !strobe_cpu)  acc.op = OP_WR;
        else                                 acc.op = OP_RD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
            beat_q  <= 2'd0;
            ilv_q   <= 1'b0;
            armed_q <= 1'b0;
        end else begin
            start_q <= start_d;
            beat_q  <= beat_d;
            ilv_q   <= ilv_d;
            armed_q <= 1'b1;
        end
    end

    // R2: a strobed cycle accesses the external address directly
    p_begin_latch_r2: assert property (@(posedge clk) disable iff (rst)
        (chip_en && (strobe_cpu || strobe_ctl)) |-> (acc_addr == addr));

    // R3: the processor strobe never yields a write
    p_cpu_read_r3: assert property (@(posedge clk) disable iff (rst)
        (chip_en && strobe_cpu) |-> (acc.op == OP_RD));

    // R5: the beat after the fourth returns to the start address
    p_wrap_start_r5: assert property (@(posedge clk) disable iff (rst)
        (kind == CY_CONT && beat_q == 2'd3) |-> (acc_addr == start_q));

    // R6: suspend repeats the previous address
    p_susp_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (armed_q && kind == CY_SUSP) |-> (acc_addr == $past(acc_addr)));

endmodule

// File: rtl/ssr_array.sv
module ssr_array
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36,
    parameter int LANE_W = 9
) (
    input  logic                       clk,
    input  logic                       rst,
    input  slot_t                      acc,
    input  logic [ADDR_W-1:0]          acc_addr,
    input  logic [DATA_W/LANE_W-1:0]   wr_lane,
    input  logic [DATA_W-1:0]          wdata,
    output logic [DATA_W-1:0]          rdata
);

    localparam int LANES = DATA_W / LANE_W;
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic              armed_q;

    always_ff @(posedge clk) begin
        if (acc.op == OP_WR) begin
            for (int i = 0; i < LANES; i++) begin
                if (wr_lane[i])
                    mem[acc_addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            armed_q <= 1'b0;
        end else begin
            armed_q <= 1'b1;
            if (acc.op == OP_RD) rdata <= mem[acc_addr];
        end
    end

    // R8: a full-lane write read back on the next cycle returns the new word
    p_read_fresh_r8: assert property (@(posedge clk) disable iff (rst)
        (armed_q && $past(acc.op == OP_WR) && $past(&wr_lane) &&
         acc.op == OP_RD && acc_addr == $past(acc_addr))
        |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/ssr_out_stage.sv
module ssr_out_stage
    import ssr_pkg::*;
#(
    parameter int DATA_W = 36,
    parameter bit PIPE   = 1'b1,
    parameter bit DCD    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  slot_t             acc,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe
);

    localparam bit EFF_DCD = PIPE && DCD;

    logic rd_now, desel_now;
    assign rd_now    = (acc.op == OP_RD);
    assign desel_now = (acc.kind == CY_DESEL);

    if (PIPE) begin : g_piped
        logic              rd_s1, ds_s1, drv_rd, oe_q;
        logic [DATA_W-1:0] out_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                rd_s1  <= 1'b0;
                ds_s1  <= 1'b0;
                drv_rd <= 1'b0;
                oe_q   <= 1'b0;
                out_q  <= '0;
            end else begin
                rd_s1  <= rd_now;
                ds_s1  <= desel_now;
                drv_rd <= rd_s1;
                oe_q   <= rd_s1 || (EFF_DCD && ds_s1 && drv_rd);
                if (rd_s1) out_q <= rdata;
            end
        end

        assign dq_out = out_q;
        assign dq_oe  = oe_q;

        // R7: registered read data two edges after the address
        p_pipe_lat_r7: assert property (@(posedge clk) disable iff (rst)
            rd_now |-> ##2 (dq_oe && dq_out == $past(rdata)));

        // R10: a write slot leaves the bus released
        p_write_slot_r10: assert property (@(posedge clk) disable iff (rst)
            (acc.op == OP_WR) |-> ##2 !dq_oe);

        if (EFF_DCD) begin : g_dcd
            // R9: double-cycle deselect keeps the bus one extra slot
            p_dcd_hold_r9: assert property (@(posedge clk) disable iff (rst)
                (desel_now && rd_s1) |-> ##2 dq_oe);
        end else begin : g_scd
            // R9: single-cycle deselect releases in the deselect slot
            p_scd_release_r9: assert property (@(posedge clk) disable iff (rst)
                desel_now |-> ##2 !dq_oe);
        end
    end else begin : g_flow
        logic oe_q;

        always_ff @(posedge clk) begin
            if (rst) oe_q <= 1'b0;
            else     oe_q <= rd_now;
        end

        assign dq_out = rdata;
        assign dq_oe  = oe_q;

        // R7: flow-through read data one edge after the address
        p_ft_lat_r7: assert property (@(posedge clk) disable iff (rst)
            rd_now |=> dq_oe);

        // R10: a write slot leaves the bus released
        p_ft_write_r10: assert property (@(posedge clk) disable iff (rst)
            (!rd_now && !desel_now) |=> !dq_oe);

        // R11: deselect releases after one slot whatever DCD says
        p_ft_scd_r11: assert property (@(posedge clk) disable iff (rst)
            desel_now |=> !dq_oe);
    end

endmodule

// File: rtl/ssr_core.sv
module ssr_core
    import ssr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36,
    parameter int LANE_W = 9,
    parameter bit PIPE   = 1'b1,
    parameter bit DCD    = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     chip_en,
    input  logic                     strobe_cpu,
    input  logic                     strobe_ctl,
    input  logic                     adv,
    input  logic                     order_ilv,
    input  logic [DATA_W/LANE_W-1:0] wr_lane,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        dq_in,
    output logic [DATA_W-1:0]        dq_out,
    output logic                     dq_oe
);

    localparam int LANES = DATA_W / LANE_W;

    slot_t             acc;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] rdata;

    ssr_burst_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk(clk), .rst(rst), .chip_en(chip_en),
        .strobe_cpu(strobe_cpu), .strobe_ctl(strobe_ctl), .adv(adv),
        .order_ilv(order_ilv), .wr_lane(wr_lane), .addr(addr),
        .acc(acc), .acc_addr(acc_addr)
    );

    ssr_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_array (
        .clk(clk), .rst(rst), .acc(acc), .acc_addr(acc_addr),
        .wr_lane(wr_lane), .wdata(dq_in), .rdata(rdata)
    );

    ssr_out_stage #(.DATA_W(DATA_W), .PIPE(PIPE), .DCD(DCD)) u_out (
        .clk(clk), .rst(rst), .acc(acc), .rdata(rdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

endmodule

// File: tb/tb_ssr_core.sv
`timescale 1ns/1ps

module ssr_model #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 36,
    parameter int LANE_W = 9,
    parameter int LANES  = 4,
    parameter bit PIPE   = 1'b1,
    parameter bit DCD    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              scpu,
    input  logic              sctl,
    input  logic              adv,
    input  logic              ilv,
    input  logic [LANES-1:0]  lane,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              exp_oe,
    output logic [DATA_W-1:0] exp_dq
);
    typedef struct packed {
        logic              rd;
        logic              ds;
        logic [DATA_W-1:0] d;
    } ev_t;

    ev_t               hist[$];
    logic [DATA_W-1:0] mem [0:(1<<ADDR_W)-1];
    int                start, beats;
    bit                ilv_q;

    always @(posedge clk) begin
        ev_t e;
        int  a;
        bit  wr;
        if (rst) begin
            hist.delete();
            exp_oe = 1'b0;
            exp_dq = '0;
            start  = 0;
            beats  = 0;
            ilv_q  = 1'b0;
        end else begin
            if (chip_en) begin
                if (scpu || sctl) begin
                    start = int'(addr);
                    beats = 0;
                    ilv_q = ilv;
                end else if (adv) begin
                    beats = (beats + 1) % 4;
                end
            end
            a  = (start & ~3) | (ilv_q ? ((start & 3) ^ beats) : (((start & 3) + beats) % 4));
            wr = chip_en && !scpu && (lane != '0);
            e.rd = chip_en && !wr;
            e.ds = !chip_en;
            e.d  = '0;
            if (wr) begin
                for (int i = 0; i < LANES; i++)
                    if (lane[i]) mem[a][i*LANE_W +: LANE_W] = din[i*LANE_W +: LANE_W];
            end
            if (e.rd) e.d = mem[a];
            hist.push_front(e);
            if (hist.size() > 3) void'(hist.pop_back());
            if (!PIPE) begin
                exp_oe = e.rd;
                if (e.rd) exp_dq = e.d;
            end else if (hist.size() >= 2 && hist[1].rd) begin
                exp_oe = 1'b1;
                exp_dq = hist[1].d;
            end else begin
                exp_oe = DCD && hist.size() >= 3 && hist[1].ds && hist[2].rd;
            end
        end
    end
endmodule

module tb_ssr_core;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 36;
    localparam int LANE_W = 9;
    localparam int LANES  = DATA_W / LANE_W;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic              rst, chip_en, scpu, sctl, adv, ilv;
    logic [LANES-1:0]  lane;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] din;

    logic              oe_p, oe_f, eoe_p, eoe_f;
    logic [DATA_W-1:0] dq_p, dq_f, edq_p, edq_f;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    bit    done   = 1'b0;
    string phase  = "R1";

    ssr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .PIPE(1'b1), .DCD(1'b1)) dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .strobe_cpu(scpu), .strobe_ctl(sctl),
        .adv(adv), .order_ilv(ilv), .wr_lane(lane), .addr(addr), .dq_in(din),
        .dq_out(dq_p), .dq_oe(oe_p)
    );

    ssr_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .PIPE(1'b0), .DCD(1'b1)) dut_ft (
        .clk(clk), .rst(rst), .chip_en(chip_en), .strobe_cpu(scpu), .strobe_ctl(sctl),
        .adv(adv), .order_ilv(ilv), .wr_lane(lane), .addr(addr), .dq_in(din),
        .dq_out(dq_f), .dq_oe(oe_f)
    );

    ssr_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES),
                .PIPE(1'b1), .DCD(1'b1)) m_pipe (
        .clk(clk), .rst(rst), .chip_en(chip_en), .scpu(scpu), .sctl(sctl), .adv(adv),
        .ilv(ilv), .lane(lane), .addr(addr), .din(din), .exp_oe(eoe_p), .exp_dq(edq_p)
    );

    // R11: flow-through model ignores the deselect setting
    ssr_model #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .LANES(LANES),
                .PIPE(1'b0), .DCD(1'b0)) m_flow (
        .clk(clk), .rst(rst), .chip_en(chip_en), .scpu(scpu), .sctl(sctl), .adv(adv),
        .ilv(ilv), .lane(lane), .addr(addr), .din(din), .exp_oe(eoe_f), .exp_dq(edq_f)
    );

    task automatic chk(input string who, input string req,
                       input logic oe, input logic [DATA_W-1:0] dq,
                       input logic eoe, input logic [DATA_W-1:0] edq);
        checks++;
        if (oe !== eoe || dq !== edq) begin
            errors++;
            $display("FAIL %s %s: oe=%b dq=%h expected oe=%b dq=%h", req, who, oe, dq, eoe, edq);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("piped", phase, oe_p, dq_p, eoe_p, edq_p);
            chk("flow", (phase == "R9") ? "R11" : phase, oe_f, dq_f, eoe_f, edq_f);
        end
    end

    task automatic drive(input bit c, input bit p, input bit q, input bit a, input bit o,
                         input logic [LANES-1:0] l, input logic [ADDR_W-1:0] ad,
                         input logic [DATA_W-1:0] d);
        chip_en = c; scpu = p; sctl = q; adv = a; ilv = o;
        lane = l; addr = ad; din = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, '0, '0, '0);
    endtask

    function automatic logic [DATA_W-1:0] pat(input int a);
        return DATA_W'(36'h5A5000000 ^ (a * 32'h01030507));
    endfunction

    initial begin
        rst = 1'b1;
        chip_en = 0; scpu = 0; sctl = 0; adv = 0; ilv = 0; lane = '0; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        // R1: reset state
        chk("piped", "R1", oe_p, dq_p, 1'b0, '0);
        chk("flow", "R1", oe_f, dq_f, 1'b0, '0);
        idle(2);

        // R2: fill every word with a known value through controller-strobed writes
        phase = "R2";
        for (int a = 0; a < (1 << ADDR_W); a++)
            drive(1, 0, 1, 0, 0, '1, ADDR_W'(a), pat(a));
        idle(2);

        // R4: linear burst starting at 0x12 reads 12,13,10,11
        phase = "R4";
        drive(1, 1, 0, 0, 0, '0, 8'h12, '0);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, '0, '0, '0);
        idle(3);
        // R4: interleaved write burst from 0x21 then interleaved read from 0x22
        drive(1, 0, 1, 0, 1, '1, 8'h21, 36'hA00000001);
        drive(1, 0, 0, 1, 0, '1, '0, 36'hA00000002);
        drive(1, 0, 0, 1, 0, '1, '0, 36'hA00000003);
        drive(1, 0, 0, 1, 0, '1, '0, 36'hA00000004);
        drive(1, 1, 0, 0, 1, '0, 8'h22, '0);
        for (int i = 0; i < 3; i++) drive(1, 0, 0, 1, 0, '0, '0, '0);
        idle(3);

        // R5: eight beats wrap through the four addresses twice
        phase = "R5";
        drive(1, 0, 1, 0, 0, '0, 8'h1E, '0);
        for (int i = 0; i < 7; i++) drive(1, 0, 0, 1, 0, '0, '0, '0);
        idle(3);

        // R3: processor strobe with write lanes set reads, memory kept
        phase = "R3";
        drive(1, 1, 0, 0, 0, '1, 8'h40, 36'hBADBADBAD);
        drive(1, 1, 1, 0, 0, '1, 8'h41, 36'hBADBADBAD);
        drive(1, 0, 1, 0, 0, '0, 8'h40, '0);
        drive(1, 0, 1, 0, 0, '0, 8'h41, '0);
        idle(3);

        // R6: suspended writes overwrite the same word, suspended reads repeat it
        phase = "R6";
        drive(1, 0, 1, 0, 0, '1, 8'h30, 36'h111111111);
        drive(1, 0, 0, 0, 0, '1, '0, 36'h222222222);
        drive(1, 0, 0, 0, 0, '0, '0, '0);
        drive(1, 0, 0, 0, 0, '0, '0, '0);
        drive(1, 0, 0, 1, 0, '0, '0, '0);
        idle(3);

        // R8: partial lane write then read of the same word next cycle
        phase = "R8";
        drive(1, 0, 1, 0, 0, 4'b0101, 8'h11, 36'hFFFFFFFFF);
        drive(1, 0, 0, 0, 0, '0, '0, '0);
        drive(1, 0, 1, 0, 0, 4'b1000, 8'h50, 36'h123456789);
        drive(1, 0, 1, 0, 0, '0, 8'h50, '0);
        idle(3);

        // R10: read and write alternating every cycle
        phase = "R10";
        drive(1, 0, 1, 0, 0, '0, 8'h10, '0);
        drive(1, 0, 1, 0, 0, '1, 8'h60, 36'h0CAFE0001);
        drive(1, 0, 1, 0, 0, '0, 8'h60, '0);
        drive(1, 0, 1, 0, 0, '1, 8'h61, 36'h0CAFE0002);
        drive(1, 0, 1, 0, 0, '0, 8'h61, '0);
        drive(1, 0, 1, 0, 0, '0, 8'h62, '0);
        idle(3);

        // R9: deselects after reads, ignored strobes and writes, burst state held
        phase = "R9";
        drive(1, 0, 1, 0, 0, '0, 8'h70, '0);
        drive(0, 0, 1, 0, 0, '1, 8'h70, 36'hDEADDEADD);
        drive(0, 1, 0, 1, 0, '0, 8'h05, '0);
        drive(1, 0, 0, 0, 0, '0, '0, '0);
        drive(0, 0, 0, 0, 0, '0, '0, '0);
        drive(1, 0, 0, 1, 0, '0, '0, '0);
        drive(1, 0, 0, 1, 0, '0, '0, '0);
        drive(0, 0, 0, 0, 0, '0, '0, '0);
        drive(1, 0, 0, 1, 0, '0, '0, '0);
        idle(3);

        // R7: random mixed traffic over the whole array
        phase = "R7";
        for (int i = 0; i < 600; i++)
            drive(($urandom % 8) != 0, ($urandom % 6) == 0, ($urandom % 5) == 0,
                  ($urandom % 2) == 1, ($urandom % 2) == 1,
                  (($urandom % 3) == 0) ? LANES'($urandom) : '0,
                  ADDR_W'($urandom), {4'($urandom), 32'($urandom)});
        idle(4);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R7 watchdog expired: oe=%b expected run to end", oe_p);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule